// File: doc/BRIEF.md
# Banked Command, Status and Interrupt Register File

This block is the byte-wide control window of a network controller. A host writes and reads eight-bit registers through a four-bit offset. Offset zero always reaches the command register. The two top bits of that register choose a page, which gives the other fifteen offsets their meaning. The block holds an interrupt status byte, an interrupt mask, a transmit status byte, a transmit start page and three 16-bit values: transmit length, remote DMA address and remote DMA count. Each 16-bit value is loaded as two bytes.

The receive, transmit and DMA engines report events on a vector of set lines, and each line sets one status bit. A single level interrupt output is raised while an unmasked status bit other than the reset-complete flag is set. When the host issues a transmit command, the block emits a one-cycle transmit request and completes the status handshake at once. The frame itself is moved by another block, which uses the page and length presented on the outputs. A remote DMA command with a zero byte count completes immediately.

All pins are plain control and status signals. There is no streaming interface and no back-pressure. Writes take effect on the clock edge where `bus_wr` is high, and `bus_rdata` follows `bus_addr` and the current page combinationally.

Top module: `nic_regfile`

## Requirements
- R1: Offset 0 reads and writes the command register on every page. For any other offset the effective address is (command bits 7:6)*16 + offset.
- R2: After reset, command = 0x01, status = 0x80, and mask, transmit status, transmit page and the three 16-bit values are 0. `irq` and `tx_req` are low.
- R3: `irq` is high exactly when (status AND mask AND 0x7F) is nonzero, so status bit 7 alone never raises it.
- R4: Writing effective address 0x07 clears each status bit 6:0 written as 1. Bits written as 0, and bit 7, are unchanged.
- R5: A command write with bit 0 clear clears status bit 7. Only reset sets bit 7 again.
- R6: A command write with bit 0 clear and bit 3 or bit 4 set, while the remote count is 0, sets status bit 6 on that edge. With a nonzero count it does not.
- R7: A command write with bit 0 clear and bit 2 set pulses `tx_req` for the following cycle. It sets transmit status to 0x01, sets status bit 1, and stores the command with bit 2 cleared. With bit 0 set, no transmit starts.
- R8: Writable effective addresses are 0x04 (transmit page), 0x05/0x06 (transmit length low/high), 0x08/0x09 (remote address low/high), 0x0A/0x0B (remote count low/high) and 0x0F (mask). Writing one byte leaves the other byte unchanged.
- R9: Readable effective addresses are 0x04 (transmit status), 0x07 (status), 0x08/0x09 (remote address), 0x24 (transmit page), 0x25/0x26 (transmit length), 0x2A/0x2B (remote count) and 0x2F (mask). All others read 0.
- R10: `evt_set[i]` sets status bit i (i = 0..6) on the edge. A set wins over a clear of the same bit in the same cycle.
- R11: Writes to any effective address not listed in R8, including every address on pages 1, 2 and 3, change no state.
- R12: `tx_page`, `tx_count`, `dma_addr` and `dma_count` always show the stored transmit page, transmit length, remote address and remote count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 4 | Register offset |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for the current offset and page |
| evt_set | input | 7 | Event lines setting status bits 6:0 |
| irq | output | 1 | Level interrupt |
| tx_req | output | 1 | One-cycle transmit request |
| tx_page | output | 8 | Transmit start page |
| tx_count | output | 16 | Transmit byte length |
| dma_addr | output | 16 | Remote DMA start address |
| dma_count | output | 16 | Remote DMA byte count |

## Verification
A wrong page latched in the command register shows up on the next access. Reads return zero or the wrong register, and writes land nowhere, so the error is visible on `bus_rdata` within one read. A status bit that is set or cleared wrongly shows up on `irq` in the same cycle when it is unmasked, and always on the next status read. A broken byte merge appears at once on the 16-bit outputs. Every output is compared each cycle against a behavioural model, so any divergence is caught on the first clock where it becomes visible.

// File: rtl/nic_regs_pkg.sv
package nic_regs_pkg;
  // command register bit positions
  localparam int CMD_STOP = 0;
  localparam int CMD_XMIT = 2;
  localparam int CMD_RRD  = 3;
  localparam int CMD_RWR  = 4;

  // status register bit positions
  localparam int ST_TXOK = 1;
  localparam int ST_DMA  = 6;
  localparam int ST_RST  = 7;

  localparam logic [7:0] CMD_RST_VAL  = 8'h01;
  localparam logic [7:0] STAT_RST_VAL = 8'h80;
  localparam logic [7:0] IRQ_ELIGIBLE = 8'h7F;
  localparam logic [7:0] TSR_DONE     = 8'h01;

  // effective addresses {page, offset}
  localparam logic [5:0] EA_TPG  = 6'h04;
  localparam logic [5:0] EA_TCL  = 6'h05;
  localparam logic [5:0] EA_TCH  = 6'h06;
  localparam logic [5:0] EA_STAT = 6'h07;
  localparam logic [5:0] EA_RAL  = 6'h08;
  localparam logic [5:0] EA_RAH  = 6'h09;
  localparam logic [5:0] EA_RCL  = 6'h0A;
  localparam logic [5:0] EA_RCH  = 6'h0B;
  localparam logic [5:0] EA_MASK = 6'h0F;
  localparam logic [5:0] RB_TPG  = 6'h24;
  localparam logic [5:0] RB_TCL  = 6'h25;
  localparam logic [5:0] RB_TCH  = 6'h26;
  localparam logic [5:0] RB_RCL  = 6'h2A;
  localparam logic [5:0] RB_RCH  = 6'h2B;
  localparam logic [5:0] RB_MASK = 6'h2F;
endpackage

// File: rtl/nic_word_reg.sv
module nic_word_reg #(
  parameter int BYTE_W = 8,
  localparam int WORD_W = 2 * BYTE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_lo,
  input  logic              wr_hi,
  input  logic [BYTE_W-1:0] din,
  output logic [WORD_W-1:0] q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q <= '0;
    end else begin
      if (wr_lo) q[BYTE_W-1:0]      <= din;
      if (wr_hi) q[WORD_W-1:BYTE_W] <= din;
    end
  end

  // R8: a byte write leaves the other byte untouched
  p_byte_merge_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_lo && !wr_hi) |=> $stable(q[WORD_W-1:BYTE_W]));
endmodule

// File: rtl/nic_cmd_ctrl.sv
module nic_cmd_ctrl
  import nic_regs_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_wr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              rcnt_zero,
  output logic [DATA_W-1:0] cmd_q,
  output logic [DATA_W-1:0] tsr_q,
  output logic              tx_req,
  output logic              run_wr,
  output logic              dma_zero,
  output logic              xmit_go
);
  assign run_wr   = cmd_wr & ~wdata[CMD_STOP];
  assign xmit_go  = run_wr & wdata[CMD_XMIT];
  assign dma_zero = run_wr & (wdata[CMD_RRD] | wdata[CMD_RWR]) & rcnt_zero;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd_q  <= CMD_RST_VAL;
      tsr_q  <= '0;
      tx_req <= 1'b0;
    end else begin
      tx_req <= xmit_go;
      if (cmd_wr) begin
        cmd_q <= wdata;
        if (xmit_go) cmd_q[CMD_XMIT] <= 1'b0;
      end
      if (xmit_go) tsr_q <= TSR_DONE;
    end
  end

  // R7: a request pulse coincides with a self-cleared command and done status
  p_tx_handshake_r7: assert property (@(posedge clk) disable iff (!rst_n)
    tx_req |-> (!cmd_q[CMD_XMIT] && tsr_q == TSR_DONE));
  // R1: the command register only changes on a command write
  p_cmd_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !cmd_wr |=> $stable(cmd_q));
  // R7: with the stop bit set no request follows
  p_stop_blocks_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_wr && wdata[CMD_STOP]) |=> !tx_req);
endmodule

// File: rtl/nic_irq_stat.sv
module nic_irq_stat
  import nic_regs_pkg::*;
#(
  parameter int DATA_W = 8,
  localparam int EVT_W = DATA_W - 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr_wr,
  input  logic              mask_wr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [EVT_W-1:0]  evt_set,
  input  logic              set_txok,
  input  logic              set_dma,
  input  logic              clr_rst,
  output logic [DATA_W-1:0] stat_q,
  output logic [DATA_W-1:0] mask_q,
  output logic              irq
);
  logic [DATA_W-1:0] clr_bits, set_bits, stat_nxt;

  always_comb begin
    clr_bits = clr_wr ? (wdata & IRQ_ELIGIBLE) : '0;
    set_bits = {1'b0, evt_set};
    set_bits[ST_TXOK] = set_bits[ST_TXOK] | set_txok;
    set_bits[ST_DMA]  = set_bits[ST_DMA]  | set_dma;
    stat_nxt = (stat_q & ~clr_bits) | set_bits;
    if (clr_rst) stat_nxt[ST_RST] = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stat_q <= STAT_RST_VAL;
      mask_q <= '0;
    end else begin
      stat_q <= stat_nxt;
      if (mask_wr) mask_q <= wdata;
    end
  end

  assign irq = |(stat_q & mask_q & IRQ_ELIGIBLE);

  // R5: once cleared, the reset flag stays clear until reset
  p_rst_flag_sticky_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !stat_q[ST_RST] |=> !stat_q[ST_RST]);
  // R3: the reset flag alone never asserts the interrupt
  p_rst_no_irq_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_q == STAT_RST_VAL) |-> !irq);
  // R6: a zero-length remote DMA completes on the command edge
  p_dma_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
    set_dma |=> stat_q[ST_DMA]);

  for (genvar k = 0; k < EVT_W; k++) begin : g_evt_chk
    // R10: an event sets its bit even against a simultaneous clear
    p_evt_sets_r10: assert property (@(posedge clk) disable iff (!rst_n)
      evt_set[k] |=> stat_q[k]);
  end
endmodule

// File: rtl/nic_regfile.sv
module nic_regfile
  import nic_regs_pkg::*;
#(
  parameter int OFS_W  = 4,
  parameter int DATA_W = 8,
  localparam int PAGE_W = 2,
  localparam int EA_W   = OFS_W + PAGE_W,
  localparam int WORD_W = 2 * DATA_W,
  localparam int EVT_W  = DATA_W - 1,
  localparam int NWORD  = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic [OFS_W-1:0]  bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic [EVT_W-1:0]  evt_set,
  output logic              irq,
  output logic              tx_req,
  output logic [DATA_W-1:0] tx_page,
  output logic [WORD_W-1:0] tx_count,
  output logic [WORD_W-1:0] dma_addr,
  output logic [WORD_W-1:0] dma_count
);
  localparam logic [EA_W-1:0] LO_EA [NWORD] = '{EA_TCL, EA_RAL, EA_RCL};
  localparam logic [EA_W-1:0] HI_EA [NWORD] = '{EA_TCH, EA_RAH, EA_RCH};

  logic [DATA_W-1:0] cmd_q, tsr_q, stat_q, mask_q, tpg_q;
  logic [EA_W-1:0]   ea;
  logic              cmd_sel, cmd_wr, reg_wr;
  logic              run_wr, dma_zero, xmit_go;
  logic [WORD_W-1:0] word_q [NWORD];

  assign ea      = {cmd_q[DATA_W-1 -: PAGE_W], bus_addr};
  assign cmd_sel = (bus_addr == '0);
  assign cmd_wr  = bus_wr & cmd_sel;
  assign reg_wr  = bus_wr & ~cmd_sel;

  nic_cmd_ctrl #(.DATA_W(DATA_W)) u_cmd (
    .clk      (clk),
    .rst_n    (rst_n),
    .cmd_wr   (cmd_wr),
    .wdata    (bus_wdata),
    .rcnt_zero(word_q[2] == '0),
    .cmd_q    (cmd_q),
    .tsr_q    (tsr_q),
    .tx_req   (tx_req),
    .run_wr   (run_wr),
    .dma_zero (dma_zero),
    .xmit_go  (xmit_go)
  );

  nic_irq_stat #(.DATA_W(DATA_W)) u_stat (
    .clk     (clk),
    .rst_n   (rst_n),
    .clr_wr  (reg_wr && ea == EA_STAT),
    .mask_wr (reg_wr && ea == EA_MASK),
    .wdata   (bus_wdata),
    .evt_set (evt_set),
    .set_txok(xmit_go),
    .set_dma (dma_zero),
    .clr_rst (run_wr),
    .stat_q  (stat_q),
    .mask_q  (mask_q),
    .irq     (irq)
  );

  for (genvar g = 0; g < NWORD; g++) begin : g_word
    nic_word_reg #(.BYTE_W(DATA_W)) u_word (
      .clk  (clk),
      .rst_n(rst_n),
      .wr_lo(reg_wr && ea == LO_EA[g]),
      .wr_hi(reg_wr && ea == HI_EA[g]),
      .din  (bus_wdata),
      .q    (word_q[g])
    );
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                      tpg_q <= '0;
    else if (reg_wr && ea == EA_TPG) tpg_q <= bus_wdata;
  end

  always_comb begin
    bus_rdata = '0;
    if (cmd_sel) begin
      bus_rdata = cmd_q;
    end else begin
      unique case (ea)
        EA_TPG:  bus_rdata = tsr_q;
        EA_STAT: bus_rdata = stat_q;
        EA_RAL:  bus_rdata = word_q[1][DATA_W-1:0];
        EA_RAH:  bus_rdata = word_q[1][WORD_W-1:DATA_W];
        RB_TPG:  bus_rdata = tpg_q;
        RB_TCL:  bus_rdata = word_q[0][DATA_W-1:0];
        RB_TCH:  bus_rdata = word_q[0][WORD_W-1:DATA_W];
        RB_RCL:  bus_rdata = word_q[2][DATA_W-1:0];
        RB_RCH:  bus_rdata = word_q[2][WORD_W-1:DATA_W];
        RB_MASK: bus_rdata = mask_q;
        default: bus_rdata = '0;
      endcase
    end
  end

  assign tx_page   = tpg_q;
  assign tx_count  = word_q[0];
  assign dma_addr  = word_q[1];
  assign dma_count = word_q[2];

  // R11: a write on a page other than 0 leaves every 16-bit value intact
  p_banked_ignore_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && ea[EA_W-1 -: PAGE_W] != '0) |=> ($stable(tx_count) && $stable(dma_addr) && $stable(dma_count)));
  // R12: the transmit page only moves on its own write
  p_tpg_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
    !(reg_wr && ea == EA_TPG) |=> $stable(tx_page));
endmodule

// File: tb/nic_regfile_bench.sv
`timescale 1ns/1ps
module nic_regfile_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_wr = 1'b0;
  logic [3:0]  bus_addr = '0;
  logic [7:0]  bus_wdata = '0;
  logic [6:0]  evt_set = '0;
  logic [7:0]  bus_rdata, tx_page;
  logic        irq, tx_req;
  logic [15:0] tx_count, dma_addr, dma_count;

  int n_cmp = 0;
  int n_bad = 0;

  // behavioural reference state
  int m_cmd = 'h01, m_isr = 'h80, m_imr = 0, m_tsr = 0, m_tpg = 0;
  int m_tcnt = 0, m_rsar = 0, m_rcnt = 0, m_txreq = 0;

  always #4 clk = ~clk;

  nic_regfile u_nic_regfile (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .evt_set(evt_set),
    .irq(irq), .tx_req(tx_req), .tx_page(tx_page), .tx_count(tx_count),
    .dma_addr(dma_addr), .dma_count(dma_count)
  );

  always @(posedge clk) begin
    if (!rst_n) begin
      m_cmd = 'h01; m_isr = 'h80; m_imr = 0; m_tsr = 0; m_tpg = 0;
      m_tcnt = 0; m_rsar = 0; m_rcnt = 0; m_txreq = 0;
    end else begin
      int a, d, ea, nisr, ncmd, txn;
      a = bus_addr; d = bus_wdata;
      ea = (m_cmd >> 6) * 16 + a;
      nisr = m_isr; txn = 0;
      if (bus_wr && a == 0) begin
        ncmd = d;
        if ((d & 1) == 0) begin
          nisr = nisr & 'h7f;
          if ((d & 'h18) != 0 && m_rcnt == 0) nisr = nisr | 'h40;
          if ((d & 4) != 0) begin
            m_tsr = 1; nisr = nisr | 2; ncmd = ncmd & 'hfb; txn = 1;
          end
        end
        m_cmd = ncmd;
      end else if (bus_wr) begin
        case (ea)
          'h04: m_tpg = d;
          'h05: m_tcnt = (m_tcnt & 'hff00) | d;
          'h06: m_tcnt = (m_tcnt & 'h00ff) | (d << 8);
          'h07: nisr = nisr & ~(d & 'h7f);
          'h08: m_rsar = (m_rsar & 'hff00) | d;
          'h09: m_rsar = (m_rsar & 'h00ff) | (d << 8);
          'h0a: m_rcnt = (m_rcnt & 'hff00) | d;
          'h0b: m_rcnt = (m_rcnt & 'h00ff) | (d << 8);
          'h0f: m_imr = d;
          default: ;
        endcase
      end
      m_isr = (nisr | evt_set) & 'hff;
      m_txreq = txn;
    end
  end

  function automatic int exp_rd();
    int ea;
    if (bus_addr == 0) return m_cmd;
    ea = (m_cmd >> 6) * 16 + bus_addr;
    case (ea)
      'h04: return m_tsr;
      'h07: return m_isr;
      'h08: return m_rsar & 'hff;
      'h09: return m_rsar >> 8;
      'h24: return m_tpg;
      'h25: return m_tcnt & 'hff;
      'h26: return m_tcnt >> 8;
      'h2a: return m_rcnt & 'hff;
      'h2b: return m_rcnt >> 8;
      'h2f: return m_imr;
      default: return 0;
    endcase
  endfunction

  task automatic chk(string tag, string what, int act, int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  task automatic compare_all(string tag);
    chk(tag, "rdata", bus_rdata, exp_rd());
    chk(tag, "irq", irq, ((m_isr & m_imr & 'h7f) != 0) ? 1 : 0);
    chk(tag, "tx_req", tx_req, m_txreq);
    chk("R12", "tx_page", tx_page, m_tpg);
    chk("R12", "tx_count", tx_count, m_tcnt);
    chk("R12", "dma_addr", dma_addr, m_rsar);
    chk("R12", "dma_count", dma_count, m_rcnt);
  endtask

  // one cycle: drive at the falling edge, compare shortly after
  task automatic step(string tag, bit wr, int a, int d, int ev);
    @(negedge clk);
    bus_wr = wr; bus_addr = a[3:0]; bus_wdata = d[7:0]; evt_set = ev[6:0];
    #1 compare_all(tag);
  endtask

  task automatic rd(string tag, int a);
    step(tag, 0, a, 0, 0);
  endtask

  initial begin
    #2_000_000;
    n_bad++;
    $display("FAIL watchdog: actual running expected finished");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R2 reset values
    rd("R2", 0); rd("R2", 7); rd("R2", 4); rd("R2", 8);
    // R4: clearing all of 6:0 leaves bit 7
    step("R4", 1, 7, 'hff, 0); rd("R4", 7);
    // R3: reset flag alone, fully unmasked
    step("R3", 1, 'hf, 'hff, 0); rd("R3", 7);
    // R8: byte loads on page 0
    step("R8", 1, 5, 'h34, 0); step("R8", 1, 6, 'h12, 0);
    step("R8", 1, 8, 'hcd, 0); step("R8", 1, 9, 'hab, 0);
    step("R8", 1, 4, 'h40, 0); step("R8", 1, 5, 'h99, 0);
    rd("R9", 8); rd("R9", 9);
    // R6 with zero count, command stays stopped-free
    step("R6", 1, 0, 'h0a, 0); rd("R6", 7);
    rd("R5", 7);
    step("R4", 1, 7, 'h40, 0); rd("R4", 7);
    // R6 with nonzero count
    step("R8", 1, 'ha, 'h02, 0);
    step("R6", 1, 0, 'h12, 0); rd("R6", 7);
    // R10: events and set-over-clear
    step("R10", 0, 7, 0, 'h05); rd("R3", 7);
    step("R10", 1, 7, 'h05, 'h01); rd("R10", 7);
    // R7: stop bit set blocks transmit
    step("R7", 1, 0, 'h05, 0); rd("R7", 0); rd("R7", 4);
    // R7: transmit
    step("R7", 1, 0, 'h26, 0); rd("R7", 0); rd("R7", 4); rd("R7", 7);
    // R1/R9: page 2 readback
    step("R1", 1, 0, 'h82, 0);
    rd("R9", 4); rd("R9", 5); rd("R9", 6); rd("R9", 'ha); rd("R9", 'hb); rd("R9", 'hf);
    rd("R1", 0); rd("R9", 7);
    // R11: page 2 writes ignored
    step("R11", 1, 5, 'hee, 0); step("R11", 1, 'hf, 0, 0); rd("R11", 5); rd("R11", 'hf);
    // R11: page 1 and page 3 writes ignored
    step("R1", 1, 0, 'h42, 0);
    step("R11", 1, 7, 'hff, 0); step("R11", 1, 'ha, 'h77, 0); rd("R11", 7);
    step("R1", 1, 0, 'hc2, 0);
    step("R11", 1, 4, 'h11, 0); step("R11", 1, 9, 'h22, 0);
    step("R1", 1, 0, 'h02, 0); rd("R11", 7); rd("R11", 8);
    // mixed traffic
    for (int i = 0; i < 600; i++) begin
      int a, d, ev, wr;
      a = $urandom % 16; d = $urandom % 256; ev = 0; wr = $urandom % 2;
      if ($urandom % 4 == 0) ev = $urandom % 128;
      if (a == 0 && ($urandom % 2 == 0)) d = d & 'h3e;
      step("R1", wr[0], a, d, ev);
    end
    // R2: reset again mid-run
    @(negedge clk); rst_n = 1'b0; bus_wr = 1'b0; evt_set = '0;
    @(negedge clk); rst_n = 1'b1;
    rd("R2", 0); rd("R2", 7); rd("R2", 'h5);
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule